// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column addresses of one SDRAM read or write burst, one address per clock. A memory controller gives it the burst-length code and ordering bit from its mode-register image, a start column and a one-cycle start pulse. From the next cycle on, the block emits the burst's beats in order and flags the final beat. A stop input ends a burst early. A fresh start during a burst abandons the old sequence and begins the new one.

Two orderings are provided. Sequential ordering wraps inside an aligned group of burst-length columns. Interleaved ordering XORs the start column with the beat number. A full-page length of 256 columns is accepted in sequential ordering only. It runs with no last-beat flag until a stop or a new start arrives. The block also decodes the length and ordering fields and reports whether they form a legal combination. A start under an illegal combination does nothing.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, busy_o and last_o are 0.
- R2: mode_ok_o is 1 for length codes 3'b000 (1 beat), 3'b001 (2), 3'b010 (4) and 3'b011 (8) under either ordering, and for 3'b111 (full page, 256) only when ilv_i is 0. All other combinations give 0.
- R3: A start_i sampled with mode_ok_o high makes busy_o 1 in the next cycle, with col_o equal to the sampled start_col_i (beat 0).
- R4: With ilv_i 0 and a burst length BL of 2 to 8, beat k has the upper bits of the start column and low log2(BL) bits equal to (start low bits + k) mod BL.
- R5: With ilv_i 1, beat k equals the start column XOR k.
- R6: In a full-page burst, each beat is the previous column plus 1 modulo 256. last_o stays 0, and the burst continues until a stop or a new start.
- R7: last_o is 1 exactly on beat BL-1 of a burst that is not full-page. Without a new start, busy_o is 0 in the cycle after that beat.
- R8: A stop_i sampled during a burst, without an accepted start, makes busy_o 0 in the next cycle. When start and stop coincide, the start wins.
- R9: An accepted start during a burst restarts the sequence at the new column with beat 0 and the new mode.
- R10: A start_i sampled while mode_ok_o is 0 has no effect. An idle block stays idle, and a running burst continues with its next beat.
- R11: Length and ordering are captured at start. Changes to len_code_i or ilv_i during a burst do not alter its addresses or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| len_code_i | input | 3 | Burst-length code from the mode register |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| start_i | input | 1 | Launch a burst at start_col_i |
| start_col_i | input | COL_W | Starting column |
| stop_i | input | 1 | End the running burst |
| mode_ok_o | output | 1 | Current length/ordering fields are legal |
| busy_o | output | 1 | col_o carries a valid beat |
| col_o | output | COL_W | Column address of the current beat |
| last_o | output | 1 | Current beat is the final one |

## Verification
The bench targets the following corner cases:
- Start columns that sit mid-group, so the sequential wrap happens inside the burst. A design that carries into the upper bits would leave the aligned block.
- A full-page burst started near 255, which must roll over to 0 without raising last_o.
- Restarts and stops on middle beats, plus a start and a stop in the same cycle. A wrong priority would kill the new burst.
- Reserved starts, both while idle and mid-burst, and mode-field changes mid-burst. A block that reads the live fields would change length or ordering partway through a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  output logic             ok_o,
  output logic             full_o,
  output logic [COL_W-1:0] mask_o
);
  always_comb begin
    ok_o   = 1'b0;
    full_o = 1'b0;
    mask_o = '0;
    case (len_code_e'(len_code_i))
      LEN_1:    ok_o = 1'b1;
      LEN_2:    begin ok_o = 1'b1; mask_o = COL_W'(1); end
      LEN_4:    begin ok_o = 1'b1; mask_o = COL_W'(3); end
      LEN_8:    begin ok_o = 1'b1; mask_o = COL_W'(7); end
      LEN_PAGE: begin
        ok_o   = (order_e'(ilv_i) == ORD_SEQ);
        full_o = 1'b1;
        mask_o = '1;
      end
      default:  ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] idx_o,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o,
  output logic             ilv_o
);
  logic             busy_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, idx_q, mask_q;
  logic             at_end;

  assign at_end = !full_q && (idx_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
      mask_q <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      base_q <= col_i;
      idx_q  <= '0;
      mask_q <= mask_i;
      full_q <= full_i;
      ilv_q  <= ilv_i;
    end else if (busy_q) begin
      if (stop_i || at_end) busy_q <= 1'b0;
      idx_q <= idx_q + COL_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && at_end;
  assign base_o = base_q;
  assign idx_o  = idx_q;
  assign mask_o = mask_q;
  assign full_o = full_q;
  assign ilv_o  = ilv_q;

  // R7: final beat only inside a burst and never in full-page mode
  a_r7_last_in_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (busy_o && !full_o));
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + idx_i;

  // bits above the mask keep the start column; bits inside wrap or XOR
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = !mask_i[b] ? base_i[b]
                    : (ilv_i ? (base_i[b] ^ idx_i[b]) : sum[b]);
  end
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       len_code_i,
  input  logic             ilv_i,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             stop_i,
  output logic             mode_ok_o,
  output logic             busy_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic             dec_full;
  logic [COL_W-1:0] dec_mask;
  logic             launch;
  logic [COL_W-1:0] base, idx, mask;
  logic             full, ilv;

  burst_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code_i(len_code_i),
    .ilv_i     (ilv_i),
    .ok_o      (mode_ok_o),
    .full_o    (dec_full),
    .mask_o    (dec_mask)
  );

  assign launch = start_i && mode_ok_o;

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(launch),
    .col_i   (start_col_i),
    .mask_i  (dec_mask),
    .full_i  (dec_full),
    .ilv_i   (ilv_i),
    .stop_i  (stop_i),
    .busy_o  (busy_o),
    .last_o  (last_o),
    .base_o  (base),
    .idx_o   (idx),
    .mask_o  (mask),
    .full_o  (full),
    .ilv_o   (ilv)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base_i(base),
    .idx_i (idx),
    .mask_i(mask),
    .ilv_i (ilv),
    .col_o (col_o)
  );

  a_r3_start_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch |=> (busy_o && col_o == $past(start_col_i)));

  a_r7_end_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !launch) |=> !busy_o);

  a_r8_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stop_i && !launch) |=> !busy_o);

  a_r10_reserved_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !mode_ok_o) |=> !busy_o);

  a_r6_page_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && full && !stop_i && !launch) |=>
      (busy_o && col_o == COL_W'($past(col_o) + 1'b1)));

  // R4: sequential wrap keeps the bits above the burst group
  a_r4_group_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !full && !ilv && !stop_i && !last_o && !launch) |=>
      (busy_o && ((col_o & ~mask) == ($past(col_o) & ~$past(mask)))));
endmodule

// File: tb/sdram_burst_seq_tb_top.sv
module sdram_burst_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] len_code = 3'b000;
  logic       ilv = 1'b0;
  logic       start = 1'b0;
  logic [7:0] start_col = 8'h00;
  logic       stop = 1'b0;
  logic       mode_ok, busy, last;
  logic [7:0] col;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_burst_seq #(.COL_W(8)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .len_code_i (len_code),
    .ilv_i      (ilv),
    .start_i    (start),
    .start_col_i(start_col),
    .stop_i     (stop),
    .mode_ok_o  (mode_ok),
    .busy_o     (busy),
    .col_o      (col),
    .last_o     (last)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic [2:0] code_of(input int bl);
    case (bl)
      1: return 3'b000;
      2: return 3'b001;
      4: return 3'b010;
      8: return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] c, input int bl,
                                         input bit il, input int k);
    logic [7:0] m;
    m = 8'(bl - 1);
    if (bl == 256) return 8'(c + k);
    if (il) return c ^ 8'(k);
    return (c & ~m) | (8'(c + k) & m);
  endfunction

  task automatic launch(input int bl, input bit il, input logic [7:0] c);
    @(negedge clk);
    len_code = code_of(bl); ilv = il; start_col = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_burst(input string req, input int bl, input bit il,
                           input logic [7:0] c);
    launch(bl, il, c);
    for (int k = 0; k < bl; k++) begin
      chk({req, " busy"}, busy, 1);
      chk({req, " col"}, col, exp_col(c, bl, il, k));
      chk("R7 last", last, (k == bl - 1));
      if (k < bl - 1) @(negedge clk);
    end
    @(negedge clk);
    chk("R7 idle after last", busy, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 last", last, 0);
  endtask

  task automatic t_decode();
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 2; i++) begin
        len_code = 3'(c); ilv = 1'(i);
        #1;
        chk("R2 mode_ok", mode_ok, (c <= 3) || (c == 7 && i == 0));
      end
    end
  endtask

  task automatic t_page();
    launch(256, 1'b0, 8'hFD);
    for (int k = 0; k < 6; k++) begin
      chk("R6 col", col, exp_col(8'hFD, 256, 1'b0, k));
      chk("R6 no last", last, 0);
      chk("R6 busy", busy, 1);
      if (k < 5) @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 page stop", busy, 0);
  endtask

  task automatic t_stop_mid();
    launch(8, 1'b0, 8'h5A);
    @(negedge clk);
    chk("R4 beat1", col, exp_col(8'h5A, 8, 1'b0, 1));
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 stop", busy, 0);
  endtask

  task automatic t_restart();
    launch(8, 1'b0, 8'h10);
    repeat (3) @(negedge clk);
    chk("R9 pre col", col, 8'h13);
    len_code = code_of(4); ilv = 1'b1; start_col = 8'h47; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk("R9 col", col, exp_col(8'h47, 4, 1'b1, k));
      chk("R9 last", last, (k == 3));
      if (k < 3) @(negedge clk);
    end
    @(negedge clk);
    chk("R9 end", busy, 0);
  endtask

  task automatic t_start_and_stop();
    launch(8, 1'b0, 8'h30);
    @(negedge clk);
    len_code = code_of(2); ilv = 1'b0; start_col = 8'h73; start = 1'b1; stop = 1'b1;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    chk("R8 start wins busy", busy, 1);
    chk("R8 start wins col", col, 8'h73);
    @(negedge clk);
    chk("R8 start wins beat1", col, 8'h72);
    chk("R8 start wins last", last, 1);
    @(negedge clk);
  endtask

  task automatic t_reserved();
    @(negedge clk);
    len_code = 3'b100; ilv = 1'b0; start_col = 8'h11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 idle reserved", busy, 0);
    len_code = 3'b111; ilv = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 page+ilv rejected", busy, 0);
    launch(8, 1'b0, 8'h20);
    len_code = 3'b101; start_col = 8'h99; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 burst continues", busy, 1);
    chk("R10 next beat col", col, 8'h21);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  task automatic t_mode_change();
    launch(4, 1'b0, 8'h09);
    len_code = code_of(8); ilv = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk("R11 col", col, exp_col(8'h09, 4, 1'b0, k));
      chk("R11 last", last, (k == 3));
      if (k < 3) @(negedge clk);
    end
    @(negedge clk);
    chk("R11 length kept", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    run_burst("R4 bl4", 4, 1'b0, 8'h2D);
    run_burst("R4 bl8", 8, 1'b0, 8'h13);
    run_burst("R4 bl2", 2, 1'b0, 8'h81);
    run_burst("R3 bl1", 1, 1'b0, 8'h55);
    run_burst("R5 bl8", 8, 1'b1, 8'h25);
    run_burst("R5 bl4", 4, 1'b1, 8'h3E);
    t_page();
    t_stop_mid();
    t_restart();
    t_start_and_stop();
    t_reserved();
    t_mode_change();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule